// File: doc/BRIEF.md
# Remappable Memory Address Decoder

This block turns the address phase of a 24-bit, 68000-style bus into a set of active-low chip selects: one for DRAM and seven for ROM banks. The selects follow the address combinationally and are all gated by the address strobe. Two of the ROM selects serve cartridge space.

A single register bit chooses where the two cartridge selects decode. When the bit is clear, each cartridge select owns a 64KB window near the top of the map. When the bit is set, the two selects move into a 512KB window directly above the two extra ROM selects. The extra selects and the relocated cartridge selects then form one contiguous megabyte of ROM space.

Software sets or clears the bit with a byte write to a fixed address on the upper data lane. Reset clears the bit. Unused ROM selects still decode their fixed windows even when no device is attached to them.

Top module: `mem_addr_decoder`

## Requirements
- R1: With the address strobe low, byte addresses 0x000008 through 0x3FFFFF drive ram_sel_no low and every ROM select high.
- R2: With the address strobe low, byte addresses 0x000000 through 0x000007 drive rom_sel_no[2] (main ROM) low and ram_sel_no high.
- R3: rom_sel_no[2] decodes 0xE00000–0xE3FFFF, rom_sel_no[1] decodes 0xE40000–0xE7FFFF, and rom_sel_no[0] decodes 0xE80000–0xEBFFFF.
- R4: rom_sel_no[5] decodes 0xD00000–0xD3FFFF and rom_sel_no[6] decodes 0xD40000–0xD7FFFF, in both modes.
- R5: With the remap bit clear, rom_sel_no[4] decodes 0xFA0000–0xFAFFFF and rom_sel_no[3] decodes 0xFB0000–0xFBFFFF. In this mode 0xD80000–0xDFFFFF selects nothing.
- R6: With the remap bit set, rom_sel_no[4] decodes 0xD80000–0xDBFFFF and rom_sel_no[3] decodes 0xDC0000–0xDFFFFF. In this mode 0xFA0000–0xFBFFFF selects nothing.
- R7: On a rising clock edge where as_ni=0, rw_i=0 (write), uds_ni=0 and the byte address is 0xFF9000, the remap bit takes the value of data_i[8].
- R8: The remap bit keeps its value when a cycle at 0xFF9000 is a read, has uds_ni high (only the lower byte is written), or has as_ni high, and when a write goes to any other address.
- R9: rst_ni low clears the remap bit asynchronously, so that the cartridge selects return to their 64KB windows.
- R10: With as_ni high, all selects are high. No address ever drives more than one select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 23 | Word address, bits 23..1 |
| as_ni | input | 1 | Address strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| uds_ni | input | 1 | Upper data strobe, active low |
| lds_ni | input | 1 | Lower data strobe, active low (does not affect the remap write) |
| data_i | input | 16 | Data bus; bit 8 feeds the remap bit |
| ram_sel_no | output | 1 | DRAM select, active low |
| rom_sel_no | output | 7 | ROM bank selects, active low; bit k is bank k |

## Verification
The hardest case to reach is a cartridge access that lands right after a change of the remap bit, combined with a write that looks almost valid but has the wrong strobe, direction or address. Such a write must leave the bit, and with it the cartridge window, unchanged. The stimulus mixes random decode accesses with random writes to the control address, using random strobes and data. After each write it probes both cartridge windows, so any unintended change of the bit shows up at the selects. Directed accesses hit the first and last byte of every window and the bytes just outside them.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  localparam int ADDR_W = 24;
  localparam int N_SEL  = 8;   // index 0 = DRAM, k+1 = ROM bank k
  localparam int N_WIN  = 10;
  localparam int TGT_W  = $clog2(N_SEL);

  typedef enum logic [1:0] {WIN_ALWAYS, WIN_NORMAL, WIN_REMAP} win_mode_e;

  typedef struct packed {
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
    logic [TGT_W-1:0]  tgt;
    win_mode_e         mode;
  } win_t;

  localparam win_t WIN_TABLE [N_WIN] = '{
    '{lo: 24'h000000, hi: 24'h000007, tgt: 3'd3, mode: WIN_ALWAYS}, // boot vectors
    '{lo: 24'h000008, hi: 24'h3FFFFF, tgt: 3'd0, mode: WIN_ALWAYS},
    '{lo: 24'hE00000, hi: 24'hE3FFFF, tgt: 3'd3, mode: WIN_ALWAYS},
    '{lo: 24'hE40000, hi: 24'hE7FFFF, tgt: 3'd2, mode: WIN_ALWAYS},
    '{lo: 24'hE80000, hi: 24'hEBFFFF, tgt: 3'd1, mode: WIN_ALWAYS},
    '{lo: 24'hD00000, hi: 24'hD3FFFF, tgt: 3'd6, mode: WIN_ALWAYS},
    '{lo: 24'hD40000, hi: 24'hD7FFFF, tgt: 3'd7, mode: WIN_ALWAYS},
    '{lo: 24'hFA0000, hi: 24'hFAFFFF, tgt: 3'd5, mode: WIN_NORMAL},
    '{lo: 24'hFB0000, hi: 24'hFBFFFF, tgt: 3'd4, mode: WIN_NORMAL},
    '{lo: 24'hD80000, hi: 24'hDFFFFF, tgt: 3'd5, mode: WIN_REMAP}   // split below
  };

  localparam logic [ADDR_W-1:0] REMAP_SPLIT = 24'hDC0000; // upper half -> bank 3
  localparam logic [ADDR_W-1:0] MODE_ADDR   = 24'hFF9000;
  localparam int                MODE_BIT    = 8;
endpackage

// File: rtl/addr_window.sv
module addr_window
  import addr_dec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] LO = '0,
  parameter logic [ADDR_W-1:0] HI = '1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  if (LO == '0) begin : g_from_zero
    assign hit_o = (addr_i <= HI);
  end else begin : g_range
    assign hit_o = (addr_i >= LO) && (addr_i <= HI);
  end
endmodule

// File: rtl/addr_sel_decode.sv
module addr_sel_decode
  import addr_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              as_ni,
  input  logic              remap_i,
  output logic [N_SEL-1:0]  sel_no
);
  logic [N_WIN-1:0] hit;
  logic [N_WIN-1:0] en;
  logic [N_SEL-1:0] act;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    addr_window #(.LO(WIN_TABLE[w].lo), .HI(WIN_TABLE[w].hi)) u_win (
      .addr_i(addr_i),
      .hit_o (hit[w])
    );
    if (WIN_TABLE[w].mode == WIN_NORMAL) begin : g_norm
      assign en[w] = ~remap_i;
    end else if (WIN_TABLE[w].mode == WIN_REMAP) begin : g_remap
      assign en[w] = remap_i;
    end else begin : g_always
      assign en[w] = 1'b1;
    end
  end

  always_comb begin
    act = '0;
    for (int w = 0; w < N_WIN; w++) begin
      if (hit[w] && en[w]) begin
        // remapped cart region splits into two 256KB halves
        if (WIN_TABLE[w].mode == WIN_REMAP && addr_i >= REMAP_SPLIT)
          act[WIN_TABLE[w].tgt - 3'd1] = 1'b1;
        else
          act[WIN_TABLE[w].tgt] = 1'b1;
      end
    end
  end

  assign sel_no = ~(act & {N_SEL{~as_ni}});

  always_comb begin
    if (!as_ni && addr_i < 24'h8 && !$isunknown(addr_i))
      a_r2_vector_not_ram: assert (sel_no[0] && !sel_no[3]);
  end
endmodule

// File: rtl/remap_mode_reg.sv
module remap_mode_reg
  import addr_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              as_ni,
  input  logic              rw_i,
  input  logic              uds_ni,
  input  logic [15:0]       data_i,
  output logic              remap_o
);
  logic wr_hit;
  assign wr_hit = ~as_ni & ~rw_i & ~uds_ni & (addr_i == MODE_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     remap_o <= 1'b0;
    else if (wr_hit) remap_o <= data_i[MODE_BIT];
  end

  a_r8_hold_on_non_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_ni || rw_i || uds_ni) |=> $stable(remap_o));

  a_r9_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> !remap_o);
endmodule

// File: rtl/mem_addr_decoder.sv
module mem_addr_decoder
  import addr_dec_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [23:1] addr_i,
  input  logic        as_ni,
  input  logic        rw_i,
  input  logic        uds_ni,
  input  logic        lds_ni,
  input  logic [15:0] data_i,
  output logic        ram_sel_no,
  output logic [6:0]  rom_sel_no
);
  logic [ADDR_W-1:0] byte_addr;
  logic              remap_q;
  logic [N_SEL-1:0]  sel_n;
  logic              unused_lds;

  assign byte_addr  = {addr_i, 1'b0};
  assign unused_lds = lds_ni;

  remap_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (byte_addr),
    .as_ni  (as_ni),
    .rw_i   (rw_i),
    .uds_ni (uds_ni),
    .data_i (data_i),
    .remap_o(remap_q)
  );

  addr_sel_decode u_dec (
    .addr_i (byte_addr),
    .as_ni  (as_ni),
    .remap_i(remap_q),
    .sel_no (sel_n)
  );

  assign ram_sel_no = sel_n[0];
  assign rom_sel_no = sel_n[N_SEL-1:1];

  a_r10_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~{rom_sel_no, ram_sel_no}));

  a_r10_strobe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |-> (&{rom_sel_no, ram_sel_no}));

  a_r5_remap_region_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!remap_q && byte_addr >= 24'hD80000 && byte_addr <= 24'hDFFFFF)
      |-> (&{rom_sel_no, ram_sel_no}));

  a_r6_cart_windows_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_q && byte_addr >= 24'hFA0000 && byte_addr <= 24'hFBFFFF)
      |-> (&{rom_sel_no, ram_sel_no}));
endmodule

// File: tb/tb_mem_addr_decoder.sv
`timescale 1ns/1ps
module tb_mem_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:1] addr_i = '0;
  logic        as_ni = 1'b1, rw_i = 1'b1, uds_ni = 1'b1, lds_ni = 1'b1;
  logic [15:0] data_i = '0;
  logic        ram_sel_no;
  logic [6:0]  rom_sel_no;

  int n_run = 0, n_fail = 0;
  logic model_remap = 1'b0;

  always #2.5 clk = ~clk;

  mem_addr_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .as_ni(as_ni), .rw_i(rw_i),
    .uds_ni(uds_ni), .lds_ni(lds_ni), .data_i(data_i),
    .ram_sel_no(ram_sel_no), .rom_sel_no(rom_sel_no)
  );

  function automatic logic [7:0] ref_sel(logic [23:0] a, logic asn, logic m);
    logic [7:0] act = '0;
    if (a < 24'h8)                              act[3] = 1'b1;
    else if (a <= 24'h3FFFFF)                   act[0] = 1'b1;
    else if (a >= 24'hE00000 && a <= 24'hE3FFFF) act[3] = 1'b1;
    else if (a >= 24'hE40000 && a <= 24'hE7FFFF) act[2] = 1'b1;
    else if (a >= 24'hE80000 && a <= 24'hEBFFFF) act[1] = 1'b1;
    else if (a >= 24'hD00000 && a <= 24'hD3FFFF) act[6] = 1'b1;
    else if (a >= 24'hD40000 && a <= 24'hD7FFFF) act[7] = 1'b1;
    else if (m) begin
      if (a >= 24'hD80000 && a <= 24'hDBFFFF)      act[5] = 1'b1;
      else if (a >= 24'hDC0000 && a <= 24'hDFFFFF) act[4] = 1'b1;
    end else begin
      if (a >= 24'hFA0000 && a <= 24'hFAFFFF)      act[5] = 1'b1;
      else if (a >= 24'hFB0000 && a <= 24'hFBFFFF) act[4] = 1'b1;
    end
    return asn ? 8'hFF : ~act;
  endfunction

  function automatic string req_of(logic [23:0] a, logic asn, logic m);
    if (asn) return "R10";
    if (a < 24'h8) return "R2";
    if (a <= 24'h3FFFFF) return "R1";
    if (a >= 24'hE00000 && a <= 24'hEBFFFF) return "R3";
    if (a >= 24'hD00000 && a <= 24'hD7FFFF) return "R4";
    return m ? "R6" : "R5";
  endfunction

  task automatic probe(logic [23:0] a, logic asn, string tag);
    logic [7:0] exp_v, got_v;
    @(negedge clk);
    addr_i = a[23:1]; as_ni = asn; rw_i = 1'b1; uds_ni = asn; lds_ni = asn;
    #1;
    exp_v = ref_sel({a[23:1], 1'b0}, asn, model_remap);
    got_v = {rom_sel_no, ram_sel_no};
    n_run++;
    if (got_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s addr=%h remap=%0b got=%b exp=%b", tag, a, model_remap, got_v, exp_v);
    end
  endtask

  task automatic bus_write(logic [23:0] a, logic rw, logic uds, logic lds, logic asn,
                           logic [15:0] d);
    @(negedge clk);
    addr_i = a[23:1]; as_ni = asn; rw_i = rw; uds_ni = uds; lds_ni = lds; data_i = d;
    @(posedge clk);
    #1;
    if (!asn && !rw && !uds && a[23:1] == 23'h7FC800) model_remap = d[8];
    @(negedge clk);
    as_ni = 1'b1; rw_i = 1'b1; uds_ni = 1'b1; lds_ni = 1'b1;
  endtask

  task automatic probe_carts(string tag);
    probe(24'hFA0010, 1'b0, tag);
    probe(24'hFB8000, 1'b0, tag);
    probe(24'hD80000, 1'b0, tag);
    probe(24'hDFFFFE, 1'b0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] edges [] = '{24'h000000, 24'h000006, 24'h000008, 24'h3FFFFE, 24'h400000,
      24'hCFFFFE, 24'hD00000, 24'hD3FFFE, 24'hD40000, 24'hD7FFFE, 24'hD80000,
      24'hDBFFFE, 24'hDC0000, 24'hDFFFFE, 24'hE00000, 24'hE3FFFE, 24'hE40000,
      24'hE7FFFE, 24'hE80000, 24'hEBFFFE, 24'hEC0000, 24'hF9FFFE, 24'hFA0000,
      24'hFAFFFE, 24'hFB0000, 24'hFBFFFE, 24'hFC0000, 24'hFF9000};
    logic [23:0] bases [] = '{24'h000000, 24'h200000, 24'hD00000, 24'hD40000,
      24'hD80000, 24'hDC0000, 24'hE00000, 24'hE80000, 24'hFA0000, 24'hFB0000};
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    // R9: reset state, cartridges at normal windows
    probe_carts("R9");
    rst_ni = 1'b1;
    probe(24'h100000, 1'b1, "R10");
    foreach (edges[i]) probe(edges[i], 1'b0, req_of(edges[i], 1'b0, 1'b0));

    // R7: set remap via upper byte
    bus_write(24'hFF9000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0100);
    probe_carts("R7");
    foreach (edges[i]) probe(edges[i], 1'b0, req_of(edges[i], 1'b0, 1'b1));

    // R8: near-miss writes leave the bit set
    bus_write(24'hFF9000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000); probe_carts("R8");
    bus_write(24'hFF9000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000); probe_carts("R8");
    bus_write(24'hFF9000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000); probe_carts("R8");
    bus_write(24'hFF9002, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000); probe_carts("R8");

    // R9: async reset clears the bit
    @(negedge clk); #1 rst_ni = 1'b0; model_remap = 1'b0;
    #3 rst_ni = 1'b1;
    probe_carts("R9");

    // R7 clear path after a set
    bus_write(24'hFF9000, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF); probe_carts("R7");
    bus_write(24'hFF9000, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFEFF); probe_carts("R7");

    for (int k = 0; k < 6000; k++) begin
      int unsigned r = $urandom_range(0, 99);
      if (r < 6) begin
        logic [23:0] wa = ($urandom_range(0, 3) == 0) ? 24'hFF9002 : 24'hFF9000;
        bus_write(wa, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
                  1'($urandom), 1'($urandom_range(0, 5) == 0), 16'($urandom));
        probe_carts("R8");
      end else begin
        logic [23:0] a;
        logic asn = ($urandom_range(0, 9) == 0);
        if (r < 60) a = bases[$urandom_range(0, bases.size() - 1)] + 24'($urandom_range(0, 24'h7FFFF));
        else a = 24'($urandom);
        a[0] = 1'b0;
        probe(a, asn, req_of(a, asn, model_remap));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule